// File: doc/BRIEF.md
# Five-to-two stored-carry encoder

This block is a purely combinational compressor. It takes five unsigned words of the same width and returns two words whose sum equals the sum of the five, modulo 2 to the power of the width. It is used as one level of a multi-operand addition tree: several of these encoders can be arranged so that many operands shrink to two, and a single two-operand adder then yields the final total. That final adder is not part of this block.

The word is split into bit-column pairs. Each pair is handled by a counter cell that takes the five bits of its lower column (weight 1) and the five bits of its upper column (weight 2) and returns a 4-bit count: the ones in the lower column plus twice the ones in the upper column. The largest count is 5 + 10 = 15, so four bits always suffice. The cell is built only from full adders used as (3,2) counters, six of them per cell. The low two bits of each count stay in place in the first result word; the high two bits move up by two columns into the second result word. The count bits of the topmost cell that would land at or above the word width are discarded, which is what makes the identity hold modulo 2 to the width. The width must be even.

There is no clock, no reset and no state; the result settles from the inputs alone.

Top module: `penta_compress`

## Requirements
- R1: For any five inputs, `(sum_word + shift_word) mod 2^WIDTH` equals `(op_a + op_b + op_c + op_d + op_e) mod 2^WIDTH`.
- R2: Bits 1 and 0 of `shift_word` are always 0.
- R3: For every cell index j (0 to WIDTH/2-1), `sum_word[2j+1:2j]` equals the low two bits of the cell count C(j) = (number of ones among the five inputs at bit 2j) + 2 × (number of ones among the five inputs at bit 2j+1).
- R4: For every cell index j below WIDTH/2-1, `shift_word[2j+3:2j+2]` equals bits 3 and 2 of C(j); bits 3 and 2 of the top cell's count appear nowhere in the outputs.
- R5: When all five inputs are zero, both outputs are zero.
- R6: When all five inputs are all-ones, every cell count is 15, so `sum_word` is all-ones and `shift_word` is all-ones except bits 1 and 0, which are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_c | input | WIDTH | Third operand |
| op_d | input | WIDTH | Fourth operand |
| op_e | input | WIDTH | Fifth operand |
| sum_word | output | WIDTH | In-place low bits of every cell count |
| shift_word | output | WIDTH | High bits of every cell count, moved up two columns |

## Verification
The bench runs a four-bit instance and drives every one of the 1024 input combinations into each of the two cells, with the other cell fed a different permutation of the same codes, and then adds random and extreme vectors. A cell that mis-weights its upper column, or a full adder with a wrong carry, would break the per-cell count checks and the modular sum identity. The all-ones vector reaches count 15 in every cell; a design that wired the high count bits one column off or let the top cell's bits wrap into the low columns would show a wrong `shift_word` there. The zero vector and the fixed zeros in the bottom two bits of `shift_word` catch a design that feeds a stray constant or a wrapped carry into those positions.

// File: rtl/penta_pkg.sv
package penta_pkg;

    localparam int OPERANDS  = 5;
    localparam int CNT_BITS  = 4;

    typedef logic [CNT_BITS-1:0] cnt_t;
    typedef logic [OPERANDS-1:0] col_t;

endpackage

// File: rtl/penta_fa.sv
module penta_fa (
    input  logic in_x,
    input  logic in_y,
    input  logic in_z,
    output logic sum_o,
    output logic cy_o
);

    assign sum_o = in_x ^ in_y ^ in_z;
    assign cy_o  = (in_x & in_y) | (in_z & (in_x ^ in_y));

endmodule

// File: rtl/penta_pair_count.sv
module penta_pair_count
    import penta_pkg::*;
(
    input  col_t w1_bits,
    input  col_t w2_bits,
    output cnt_t cnt
);

    // weight-1 column
    logic s_a, c_a, s_b, c_b;
    // weight-2 column
    logic s_c, c_c, s_d, c_d, s_e, c_e;
    // weight-4 column
    logic s_f, c_f;

    penta_fa u_fa_a (.in_x(w1_bits[0]), .in_y(w1_bits[1]), .in_z(w1_bits[2]),
                     .sum_o(s_a), .cy_o(c_a));
    penta_fa u_fa_b (.in_x(s_a), .in_y(w1_bits[3]), .in_z(w1_bits[4]),
                     .sum_o(s_b), .cy_o(c_b));

    penta_fa u_fa_c (.in_x(w2_bits[0]), .in_y(w2_bits[1]), .in_z(w2_bits[2]),
                     .sum_o(s_c), .cy_o(c_c));
    penta_fa u_fa_d (.in_x(w2_bits[3]), .in_y(w2_bits[4]), .in_z(c_a),
                     .sum_o(s_d), .cy_o(c_d));
    penta_fa u_fa_e (.in_x(s_c), .in_y(s_d), .in_z(c_b),
                     .sum_o(s_e), .cy_o(c_e));

    penta_fa u_fa_f (.in_x(c_c), .in_y(c_d), .in_z(c_e),
                     .sum_o(s_f), .cy_o(c_f));

    assign cnt = {c_f, s_f, s_e, s_b};

endmodule

// File: rtl/penta_compress.sv
module penta_compress
    import penta_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    input  logic [WIDTH-1:0] op_e,
    output logic [WIDTH-1:0] sum_word,
    output logic [WIDTH-1:0] shift_word
);

    localparam int CELLS = WIDTH / 2;

    cnt_t cell_cnt [CELLS];

    assign shift_word[1:0] = 2'b00;

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        col_t lo_col, hi_col;

        assign lo_col = {op_e[2*j],   op_d[2*j],   op_c[2*j],   op_b[2*j],   op_a[2*j]};
        assign hi_col = {op_e[2*j+1], op_d[2*j+1], op_c[2*j+1], op_b[2*j+1], op_a[2*j+1]};

        penta_pair_count u_cnt (
            .w1_bits (lo_col),
            .w2_bits (hi_col),
            .cnt     (cell_cnt[j])
        );

        assign sum_word[2*j+1:2*j] = cell_cnt[j][1:0];

        if (j < CELLS - 1) begin : g_route
            assign shift_word[2*j+3:2*j+2] = cell_cnt[j][3:2];
        end else begin : g_drop
            logic [1:0] unused_top_bits;
            assign unused_top_bits = cell_cnt[j][3:2];
        end
    end

endmodule

// File: rtl/penta_compress_chk.sv
module penta_compress_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] op_c,
    input logic [WIDTH-1:0] op_d,
    input logic [WIDTH-1:0] op_e,
    input logic [WIDTH-1:0] sum_word,
    input logic [WIDTH-1:0] shift_word
);

    localparam int CELLS = WIDTH / 2;

    logic [WIDTH-1:0] ref_total;
    logic [WIDTH-1:0] got_total;

    assign ref_total = op_a + op_b + op_c + op_d + op_e;
    assign got_total = sum_word + shift_word;

    always_comb begin
        // R1
        p_sum_match_r1: assert (got_total == ref_total);
        // R2
        p_low_zero_r2: assert (shift_word[1:0] == 2'b00);
        // R5
        if ((op_a | op_b | op_c | op_d | op_e) == '0)
            p_zero_in_r5: assert (sum_word == '0 && shift_word == '0);
        for (int j = 0; j < CELLS; j++) begin
            automatic int lo = int'(op_a[2*j]) + int'(op_b[2*j]) + int'(op_c[2*j])
                             + int'(op_d[2*j]) + int'(op_e[2*j]);
            automatic int hi = int'(op_a[2*j+1]) + int'(op_b[2*j+1]) + int'(op_c[2*j+1])
                             + int'(op_d[2*j+1]) + int'(op_e[2*j+1]);
            automatic int c  = lo + 2 * hi;
            // R3
            p_cell_low_r3: assert (int'(sum_word[2*j +: 2]) == (c % 4));
            // R4
            if (j < CELLS - 1)
                p_cell_high_r4: assert (int'(shift_word[2*j+2 +: 2]) == (c / 4));
        end
    end

endmodule

bind penta_compress penta_compress_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/penta_compress_tb.sv
`timescale 1ns/1ps
module penta_compress_tb;

    localparam int W     = 4;
    localparam int CELLS = W / 2;
    localparam int WDOG  = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, c, d, e;
    logic [W-1:0] sw, hw;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    penta_compress #(.WIDTH(W)) u_dut (
        .op_a(a), .op_b(b), .op_c(c), .op_d(d), .op_e(e),
        .sum_word(sw), .shift_word(hw)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d (a=%h b=%h c=%h d=%h e=%h)",
                     req, got, exp, a, b, c, d, e);
        end
    endtask

    function automatic int cnt_of(input int j, input logic [W-1:0] v0, v1, v2, v3, v4);
        int lo, hi;
        lo = int'(v0[2*j]) + int'(v1[2*j]) + int'(v2[2*j]) + int'(v3[2*j]) + int'(v4[2*j]);
        hi = int'(v0[2*j+1]) + int'(v1[2*j+1]) + int'(v2[2*j+1]) + int'(v3[2*j+1]) + int'(v4[2*j+1]);
        return lo + 2 * hi;
    endfunction

    task automatic apply_and_check(input logic [W-1:0] v0, v1, v2, v3, v4);
        int mod, exp_sum;
        @(posedge clk);
        a = v0; b = v1; c = v2; d = v3; e = v4;
        @(negedge clk);
        mod = 1 << W;
        exp_sum = (int'(v0) + int'(v1) + int'(v2) + int'(v3) + int'(v4)) % mod;
        chk("R1 modular sum", (int'(sw) + int'(hw)) % mod, exp_sum);
        chk("R2 shift bits 1:0", int'(hw[1:0]), 0);
        for (int j = 0; j < CELLS; j++) begin
            int cc;
            cc = cnt_of(j, v0, v1, v2, v3, v4);
            chk("R3 cell low bits", int'(sw[2*j +: 2]), cc % 4);
            if (j < CELLS - 1)
                chk("R4 cell high bits", int'(hw[2*j+2 +: 2]), cc / 4);
        end
    endtask

    function automatic logic [W-1:0] build(input int k, input int p0, input int p1);
        logic [W-1:0] r;
        r[0] = p0[k];
        r[1] = p0[5+k];
        r[2] = p1[k];
        r[3] = p1[5+k];
        return r;
    endfunction

    initial begin
        a = '0; b = '0; c = '0; d = '0; e = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: zero inputs give zero outputs
        chk("R5 zero sum_word", int'(sw), 0);
        chk("R5 zero shift_word", int'(hw), 0);

        // exhaustive per-cell sweep (R1 R3 R4)
        for (int v = 0; v < 1024; v++) begin
            int w;
            w = (v * 37 + 5) % 1024;
            apply_and_check(build(0, v, w), build(1, v, w), build(2, v, w),
                            build(3, v, w), build(4, v, w));
        end

        // R6: all-ones, every cell count 15, top bits dropped
        apply_and_check('1, '1, '1, '1, '1);
        chk("R6 all-ones sum_word", int'(sw), (1 << W) - 1);
        chk("R6 all-ones shift_word", int'(hw), (1 << W) - 4);

        // single operand only: others zero
        apply_and_check(4'hF, '0, '0, '0, '0);
        chk("R4 single operand shift_word", int'(hw), 0);
        chk("R3 single operand sum_word", int'(sw), 15);

        // random vectors
        for (int i = 0; i < 2000; i++)
            apply_and_check(W'($urandom), W'($urandom), W'($urandom),
                            W'($urandom), W'($urandom));

        // R5 again after activity
        apply_and_check('0, '0, '0, '0, '0);
        chk("R5 zero after activity", int'(sw | hw), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule